// File: doc/BRIEF.md
# Dual-Role Word FIFO

This block is one 32-bit by 32-word buffer that a data-path engine uses in one of two directions. Two activity inputs from the engine pick the role. In transmit role a register-bus host fills the buffer by writing to any address inside a window of 32 consecutive word addresses. The engine drains the buffer through a registered output that always shows the word at the read pointer, and it advances the pointer with a load strobe once it has copied that word into its shift register. In receive role the engine pushes words with a valid strobe, and the host drains them by reading from the same address window.

Occupancy, full, empty and half-full status are shown only while a role is active. With no role active, or with both activity inputs high, the buffer is idle and every status flag is low. Three sticky error bits record rejected pushes, rejected pops and conflicting activity inputs until a clear input resets them. A role that ends flushes the buffer, so each new role starts empty.

Top module: `role_fifo`

## Requirements
- R1: With only tx_active high the block is in transmit role, with only rx_active high it is in receive role, and otherwise it is idle. Host writes and engine pushes made in a role that does not own them, or while idle, leave the occupancy unchanged.
- R2: While neither activity input is high, fifo_full, fifo_empty and fifo_half are 0 and fifo_count is 0, in the same cycle the inputs change.
- R3: When tx_active and rx_active are both high, the block is idle with all status flags low, and err_conflict reads 1 from the next clock edge onward.
- R4: In transmit role a host_wr to any word address from WIN_IDX*DEPTH through WIN_IDX*DEPTH+DEPTH-1 (64 to 95 by default) stores host_wdata, and fifo_count goes up by one after that clock edge. A host_wr to an address outside that window has no effect.
- R5: eng_dout is a register that holds the word at the read pointer. It shows the first word written into an empty buffer after the edge of that write. After each eng_load edge it shows the next word, and words leave in the order they were stored.
- R6: In receive role eng_valid pushes eng_din. While host_rd is high with an address inside the window, host_rdata shows the oldest word in the same cycle, and that word is removed at the clock edge. host_rdata is 0 outside receive role, and a host_rd outside the window removes nothing.
- R7: In an active role fifo_count gives the number of stored words from 0 to 32, fifo_empty is 1 exactly when it is 0, fifo_full is 1 exactly when it is 32, and fifo_half is 1 exactly when it is 16 or more.
- R8: A push while the buffer holds 32 words is dropped, the count stays 32, and err_overrun reads 1 after that edge.
- R9: A pop while the buffer is empty removes nothing, the count stays 0, and err_underrun reads 1 after that edge.
- R10: err_clear resets err_overrun, err_underrun and err_conflict at the next edge. An error event in the same cycle as err_clear leaves its bit set.
- R11: When the active role ends, because the activity input falls or the role changes directly to the other one, both pointers and the count return to zero at the next edge. The next role starts empty, and its first stored word becomes the head.
- R12: In receive role a push and a pop in the same cycle on a non-empty buffer leave the count unchanged and keep the order of the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Engine is transmitting; selects transmit role |
| rx_active | input | 1 | Engine is receiving; selects receive role |
| err_clear | input | 1 | Clears the sticky error bits |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HOST_AW (8) | Host word address |
| host_wdata | input | DATA_W (32) | Host write data |
| host_rdata | output | DATA_W (32) | Host read data: the oldest word in receive role |
| eng_load | input | 1 | Engine has taken the head word (transmit pop) |
| eng_dout | output | DATA_W (32) | Registered head word for the engine |
| eng_valid | input | 1 | Engine push strobe (receive) |
| eng_din | input | DATA_W (32) | Engine push data |
| fifo_full | output | 1 | Buffer holds DEPTH words |
| fifo_empty | output | 1 | Buffer holds no word |
| fifo_half | output | 1 | Buffer is at least half full |
| fifo_count | output | CNT_W (6) | Occupancy |
| err_overrun | output | 1 | Sticky: push while full |
| err_underrun | output | 1 | Sticky: pop while empty |
| err_conflict | output | 1 | Sticky: both activity inputs high |

## Verification
The assertions assume that the activity inputs only change between clock edges and that the engine never expects a word from the wrong role. They do not assume that the host respects full or empty. Rejected pushes and pops are legal stimulus, and the checks on count bounds and pointer distance must hold through them. The bench drives every input one time unit after a rising edge. It walks every offset of the address window, and it deliberately crosses the full, empty and half-full thresholds, the role changes and the conflict case.

// File: rtl/role_fifo_pkg.sv
package role_fifo_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2
  } fifo_mode_e;

  // Ring pointer advance with wrap at depth.
  function automatic int unsigned ring_step(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of accepted push and pop.
  function automatic int unsigned occ_next(int unsigned c, logic push, logic pop);
    int unsigned up;
    int unsigned dn;
    up = push ? 1 : 0;
    dn = pop ? 1 : 0;
    return c + up - dn;
  endfunction

  // Half-full threshold: at least half of depth.
  function automatic logic reaches_half(int unsigned c, int unsigned depth);
    return (c * 2) >= depth;
  endfunction

endpackage

// File: rtl/role_fifo_mode.sv
module role_fifo_mode
  import role_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_active,
  input  logic       rx_active,
  output fifo_mode_e mode,
  output logic       flush,
  output logic       conflict
);

  fifo_mode_e prev_q;

  always_comb begin
    conflict = tx_active && rx_active;
    if (tx_active && !rx_active)      mode = MODE_TX;
    else if (rx_active && !tx_active) mode = MODE_RX;
    else                              mode = MODE_OFF;
  end

  // A role that was active last cycle and is not the current one ends now.
  assign flush = (prev_q != MODE_OFF) && (prev_q != mode);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= MODE_OFF;
    else        prev_q <= mode;
  end

  assert_conflict_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> (prev_q == MODE_OFF))
    else $error("conflict did not leave the block idle");

endmodule

// File: rtl/role_fifo_ptrs.sv
module role_fifo_ptrs
  import role_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] rd_ptr_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic             push_ok,
  output logic             ovf_evt,
  output logic             unf_evt
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             is_full;
  logic             is_empty;
  logic             pop_ok;
  logic [PTR_W-1:0] wr_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  assign is_full  = (cnt == FULL_CNT);
  assign is_empty = (cnt == '0);

  assign push_ok = push_req && !is_full  && !flush;
  assign pop_ok  = pop_req  && !is_empty && !flush;
  assign ovf_evt = push_req && is_full   && !flush;
  assign unf_evt = pop_req  && is_empty  && !flush;

  always_comb begin
    if (flush) begin
      wr_nxt     = '0;
      rd_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      wr_nxt     = push_ok ? PTR_W'(ring_step(32'(wr_ptr), DEPTH)) : wr_ptr;
      rd_ptr_nxt = pop_ok  ? PTR_W'(ring_step(32'(rd_ptr), DEPTH)) : rd_ptr;
      cnt_nxt    = CNT_W'(occ_next(32'(cnt), push_ok, pop_ok));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT)
    else $error("occupancy above depth");

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push_req && !pop_req && !flush) |=> (cnt == FULL_CNT))
    else $error("push into full buffer changed occupancy");

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop_req && !push_req && !flush) |=> (cnt == '0))
    else $error("pop from empty buffer changed occupancy");

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && wr_ptr == '0 && rd_ptr == '0))
    else $error("role exit did not clear pointers");

  assert_balance_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt))
    else $error("push with pop changed occupancy");

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assert_ptr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(wr_ptr - rd_ptr) == cnt[PTR_W-1:0])
        else $error("pointer distance differs from occupancy");
    end
  endgenerate

endmodule

// File: rtl/role_fifo_mem.sv
module role_fifo_mem #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [PTR_W-1:0]  rd_ptr_nxt,
  input  logic              nonempty,
  output logic [DATA_W-1:0] head
);

  logic [DATA_W-1:0] store [DEPTH];
  logic              bypass;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // The head register follows the next read pointer; a write landing on
  // that slot in the same cycle is forwarded.
  assign bypass = we && (waddr == rd_ptr_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n)      head <= '0;
    else if (bypass) head <= wdata;
    else             head <= store[rd_ptr_nxt];
  end

  assert_head_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nonempty |-> (head == store[rd_ptr]))
    else $error("head register differs from word at read pointer");

endmodule

// File: rtl/role_fifo.sv
module role_fifo
  import role_fifo_pkg::*;
#(
  parameter int  DEPTH   = 32,
  parameter int  DATA_W  = 32,
  parameter int  HOST_AW = 8,
  parameter int  WIN_IDX = 2,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_active,
  input  logic               rx_active,
  input  logic               err_clear,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               eng_load,
  output logic [DATA_W-1:0]  eng_dout,
  input  logic               eng_valid,
  input  logic [DATA_W-1:0]  eng_din,
  output logic               fifo_full,
  output logic               fifo_empty,
  output logic               fifo_half,
  output logic [CNT_W-1:0]   fifo_count,
  output logic               err_overrun,
  output logic               err_underrun,
  output logic               err_conflict
);

  localparam logic [HOST_AW-1:0] WIN_LO   = HOST_AW'(WIN_IDX * DEPTH);
  localparam logic [HOST_AW-1:0] WIN_HI   = HOST_AW'(WIN_IDX * DEPTH + DEPTH - 1);
  localparam logic [CNT_W-1:0]   FULL_CNT = CNT_W'(DEPTH);

  fifo_mode_e        mode;
  logic              flush;
  logic              conflict;
  logic              in_win;
  logic              tx_on;
  logic              rx_on;
  logic              push_req;
  logic              pop_req;
  logic [DATA_W-1:0] push_data;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  rd_ptr_nxt;
  logic [CNT_W-1:0]  cnt;
  logic              push_ok;
  logic              ovf_evt;
  logic              unf_evt;
  logic [DATA_W-1:0] head;

  role_fifo_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .mode      (mode),
    .flush     (flush),
    .conflict  (conflict)
  );

  assign in_win = (host_addr >= WIN_LO) && (host_addr <= WIN_HI);
  assign tx_on  = (mode == MODE_TX);
  assign rx_on  = (mode == MODE_RX);

  // Role routing: who pushes and who pops.
  always_comb begin
    push_req  = 1'b0;
    pop_req   = 1'b0;
    push_data = host_wdata;
    if (tx_on) begin
      push_req  = host_wr && in_win;
      pop_req   = eng_load;
      push_data = host_wdata;
    end else if (rx_on) begin
      push_req  = eng_valid;
      pop_req   = host_rd && in_win;
      push_data = eng_din;
    end
  end

  role_fifo_ptrs #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .flush      (flush),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .rd_ptr_nxt (rd_ptr_nxt),
    .cnt        (cnt),
    .push_ok    (push_ok),
    .ovf_evt    (ovf_evt),
    .unf_evt    (unf_evt)
  );

  role_fifo_mem #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W)
  ) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (push_ok),
    .waddr      (wr_ptr),
    .wdata      (push_data),
    .rd_ptr     (rd_ptr),
    .rd_ptr_nxt (rd_ptr_nxt),
    .nonempty   (cnt != '0),
    .head       (head)
  );

  assign eng_dout   = head;
  assign host_rdata = rx_on ? head : '0;

  // Status is visible only in an active role.
  always_comb begin
    if (tx_on || rx_on) begin
      fifo_count = cnt;
      fifo_full  = (cnt == FULL_CNT);
      fifo_empty = (cnt == '0);
      fifo_half  = reaches_half(32'(cnt), DEPTH);
    end else begin
      fifo_count = '0;
      fifo_full  = 1'b0;
      fifo_empty = 1'b0;
      fifo_half  = 1'b0;
    end
  end

  // Sticky errors: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_overrun  <= 1'b0;
      err_underrun <= 1'b0;
      err_conflict <= 1'b0;
    end else begin
      if (ovf_evt)        err_overrun <= 1'b1;
      else if (err_clear) err_overrun <= 1'b0;
      if (unf_evt)        err_underrun <= 1'b1;
      else if (err_clear) err_underrun <= 1'b0;
      if (conflict)       err_conflict <= 1'b1;
      else if (err_clear) err_conflict <= 1'b0;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rx_active) |->
      (!fifo_full && !fifo_empty && !fifo_half && fifo_count == '0))
    else $error("status flags active while idle");

  assert_conflict_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && rx_active) |=> err_conflict)
    else $error("conflict not recorded");

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> err_overrun)
    else $error("overrun not recorded");

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> err_underrun)
    else $error("underrun not recorded");

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !ovf_evt && !unf_evt && !conflict) |=>
      (!err_overrun && !err_underrun && !err_conflict))
    else $error("clear did not reset error bits");

  assert_idle_no_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_on && !rx_on) |-> !push_ok)
    else $error("word stored while idle");

endmodule

// File: tb/sim_role_fifo.sv
module sim_role_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int AW         = 8;
  localparam int WIN        = 2;
  localparam int BASE       = WIN * DEPTH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_active = 1'b0;
  logic        rx_active = 1'b0;
  logic        err_clear = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_load = 1'b0;
  logic [31:0] eng_dout;
  logic        eng_valid = 1'b0;
  logic [31:0] eng_din = '0;
  logic        fifo_full;
  logic        fifo_empty;
  logic        fifo_half;
  logic [5:0]  fifo_count;
  logic        err_overrun;
  logic        err_underrun;
  logic        err_conflict;

  role_fifo #(.DEPTH(DEPTH), .DATA_W(32), .HOST_AW(AW), .WIN_IDX(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .err_clear(err_clear), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_load(eng_load), .eng_dout(eng_dout), .eng_valid(eng_valid),
    .eng_din(eng_din), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .fifo_count(fifo_count), .err_overrun(err_overrun),
    .err_underrun(err_underrun), .err_conflict(err_conflict)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] mq[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pat(int i, int salt);
    return (32'(salt) * 32'h0001_0003) ^ (32'h9E37_79B9 * 32'(i + 1));
  endfunction

  // Status expected from the model while a role is active.
  task automatic chk_status(string req);
    int n;
    n = mq.size();
    chk(req, "count", 32'(fifo_count), 32'(n));
    chk(req, "empty", 32'(fifo_empty), 32'(n == 0));
    chk(req, "full",  32'(fifo_full),  32'(n == DEPTH));
    chk(req, "half",  32'(fifo_half),  32'(n >= DEPTH / 2));
  endtask

  task automatic chk_idle(string req);
    chk(req, "idle count", 32'(fifo_count), 0);
    chk(req, "idle flags", {29'd0, fifo_full, fifo_empty, fifo_half}, 0);
  endtask

  task automatic hw(int addr, logic [31:0] d);
    host_addr = 8'(addr); host_wdata = d; host_wr = 1'b1;
    tick;
    host_wr = 1'b0;
  endtask

  task automatic eload;
    eng_load = 1'b1;
    tick;
    eng_load = 1'b0;
  endtask

  task automatic epush(logic [31:0] d);
    eng_din = d; eng_valid = 1'b1;
    tick;
    eng_valid = 1'b0;
  endtask

  task automatic clear_err;
    err_clear = 1'b1;
    tick;
    err_clear = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary;
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // Reset state and idle status
    chk_idle("R2");
    chk("R10", "errors after reset", {29'd0, err_overrun, err_underrun, err_conflict}, 0);

    // R1: a host write while idle stores nothing
    hw(BASE, 32'hDEAD_0001);
    tx_active = 1'b1;
    #1;
    chk_status("R1");

    // R4 R5 R7: fill through every window offset
    for (int i = 0; i < DEPTH; i++) begin
      d = pat(i, 1);
      hw(BASE + i, d);
      mq.push_back(d);
      chk_status("R7");
      if (i == 0) chk("R5", "first head", eng_dout, d);
      if (i == 5) begin
        hw(5, 32'hBAD0_0005);
        hw(BASE + DEPTH, 32'hBAD0_0006);
        hw(BASE - 1, 32'hBAD0_0007);
        chk("R4", "outside window ignored", 32'(fifo_count), 6);
      end
    end

    // R8: overrun
    hw(BASE + 3, 32'hBAD0_0008);
    chk("R8", "count held at full", 32'(fifo_count), 32);
    chk("R8", "overrun flag", 32'(err_overrun), 1);
    chk("R8", "head unchanged", eng_dout, mq[0]);
    clear_err;
    chk("R10", "overrun cleared", 32'(err_overrun), 0);

    // R5: drain in order
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5", "head before load", eng_dout, mq[0]);
      eload;
      void'(mq.pop_front());
      chk_status("R5");
      if (i == 0) begin
        epush(32'hBAD0_0009);
        chk("R1", "engine push ignored in transmit", 32'(fifo_count), 31);
      end
    end

    // R9: underrun
    eload;
    chk("R9", "count held at zero", 32'(fifo_count), 0);
    chk("R9", "underrun flag", 32'(err_underrun), 1);
    err_clear = 1'b1; eng_load = 1'b1;
    tick;
    err_clear = 1'b0; eng_load = 1'b0;
    chk("R10", "event beats clear", 32'(err_underrun), 1);
    clear_err;
    chk("R10", "underrun cleared", 32'(err_underrun), 0);

    // R11: leaving transmit flushes
    for (int i = 0; i < 3; i++) begin
      d = pat(i, 2); hw(BASE + 10 + i, d); mq.push_back(d);
    end
    chk_status("R7");
    tx_active = 1'b0;
    #1;
    chk_idle("R2");
    tick;
    tx_active = 1'b1;
    #1;
    mq.delete();
    chk_status("R11");
    d = pat(7, 3);
    hw(BASE + 7, d); mq.push_back(d);
    chk("R11", "new head after flush", eng_dout, d);
    d = pat(8, 3); hw(BASE + 8, d); mq.push_back(d);
    chk_status("R11");

    // R11: direct switch to receive
    tx_active = 1'b0; rx_active = 1'b1;
    tick;
    mq.delete();
    chk_status("R11");

    // R6: receive fill, crossing the half threshold
    for (int i = 0; i < 20; i++) begin
      d = pat(i, 4); epush(d); mq.push_back(d);
      chk_status("R7");
    end
    hw(BASE, 32'hBAD0_000A);
    chk("R1", "host write ignored in receive", 32'(fifo_count), 20);

    for (int i = 0; i < 5; i++) begin
      host_addr = 8'(BASE + (i * 7) % DEPTH); host_rd = 1'b1;
      #1;
      chk("R6", "host read data", host_rdata, mq[0]);
      tick;
      host_rd = 1'b0;
      void'(mq.pop_front());
      chk_status("R6");
    end
    host_addr = 8'd3; host_rd = 1'b1;
    tick;
    host_rd = 1'b0;
    chk("R6", "read outside window ignored", 32'(fifo_count), 32'(mq.size()));

    // R12: push with pop
    for (int i = 0; i < 4; i++) begin
      d = pat(i, 5);
      eng_din = d; eng_valid = 1'b1;
      host_addr = 8'(BASE + 31 - i); host_rd = 1'b1;
      #1;
      chk("R12", "read data during push", host_rdata, mq[0]);
      tick;
      eng_valid = 1'b0; host_rd = 1'b0;
      void'(mq.pop_front()); mq.push_back(d);
      chk("R12", "count unchanged", 32'(fifo_count), 15);
    end

    // Fill to full and overrun via engine
    while (mq.size() < DEPTH) begin
      d = pat(mq.size(), 6); epush(d); mq.push_back(d);
    end
    chk_status("R7");
    epush(32'hBAD0_000B);
    chk("R8", "engine overrun flag", 32'(err_overrun), 1);
    chk("R8", "count held", 32'(fifo_count), 32);

    // Drain all, checking order
    while (mq.size() > 0) begin
      host_addr = 8'(BASE + mq.size() - 1); host_rd = 1'b1;
      #1;
      chk("R6", "drain order", host_rdata, mq[0]);
      tick;
      host_rd = 1'b0;
      void'(mq.pop_front());
    end
    chk_status("R6");
    clear_err;

    // R3: conflict
    d = pat(0, 7); epush(d);
    tx_active = 1'b1;
    #1;
    chk_idle("R3");
    chk("R6", "host_rdata zero outside receive", host_rdata, 0);
    tick;
    chk("R3", "conflict flag", 32'(err_conflict), 1);
    tx_active = 1'b0;
    tick;
    chk("R3", "conflict sticky", 32'(err_conflict), 1);
    clear_err;
    chk("R10", "conflict cleared", 32'(err_conflict), 0);
    rx_active = 1'b0;
    tick;
    rx_active = 1'b1;
    #1;
    mq.delete();
    chk_status("R11");

    done = 1'b1;
    summary;
    $finish;
  end

endmodule